// File: doc/BRIEF.md
# Boot-Sector Protection and Bank Decoder

This unit sits beside the command logic of a 2M-word flash array that has a boot block at one end. Given a 21-bit word address, it reports three things in the same cycle: the sector index, whether the address lies in the small 4-Mbit bank that holds the boot sectors, and the protection group that covers it. A `boot_top` input chooses where the boot block is. When it is high, the eight 4-Kword sectors sit at the top of the address space. When it is low, they sit at the bottom and the map is the mirror image. In both cases sector and group indices rise with the address.

The unit stores one protection bit per group. It also produces a write-allowed flag that the program and erase sequencer consults. That flag combines the stored bit with three overrides in a fixed order:

- acceleration mode, which wins over everything;
- a boot-lock input that keeps the two outermost boot sectors shut;
- temporary unprotect.

Protect requests set the bit of the addressed group. An unprotect request clears all bits at once, but only if every bit is already set; otherwise it is refused and an error flag is raised. A verify output returns the addressed group's bit as a 16-bit word.

Top module: `bsp_top`

## Requirements
- R1: With `boot_top`=1, a 9-bit sector field F = addr[20:12] whose upper six bits F[8:3] are all ones selects sector 63+F[2:0]. Any other F selects sector F[8:3] (0..62).
- R2: With `boot_top`=0, F[8:3]=0 selects sector F[2:0] (0..7). Any other F selects sector F[8:3]+7 (8..70).
- R3: `boot_bank` is 1 exactly for sectors 56..70 when `boot_top`=1, and for sectors 0..14 when `boot_top`=0.
- R4: Protection groups are numbered 0..24 and rise with the address.
  - Top-boot: sector 0 is group 0; sectors 1..3 are group 1; sectors 4..59 form groups 2..15 in fours; sectors 60..62 are group 16; sectors 63..70 are groups 17..24.
  - Bottom-boot: sectors 0..7 are groups 0..7; sectors 8..10 are group 8; sectors 11..66 form groups 9..22 in fours; sectors 67..69 are group 23; sector 70 is group 24.
- R5: After reset all group bits are clear and `unprot_err` is 0.
- R6: A cycle with `prot_set`=1 and `unprot_all`=0 sets the bit of the addressed group at the next clock edge and leaves all other bits unchanged.
- R7: A cycle with `unprot_all`=1 behaves according to the stored bits.
  - If every bit is set, all bits clear at the next edge and `unprot_err` becomes 0.
  - Otherwise the bits stay unchanged, `unprot_err` becomes 1, and any `prot_set` in that same cycle is ignored.
  - `unprot_err` holds its value between unprotect requests.
- R8: `verify_data` is 16'h0001 when the addressed group is protected and 16'h0000 when it is not.
- R9: With `accel`=0, `temp_unprot`=0 and `boot_lock_n`=1, `wr_ok` is the inverse of the addressed group's bit.
- R10: With `accel`=0 and `boot_lock_n`=0, `wr_ok` is 0 for the two outermost boot sectors whatever the stored bits and `temp_unprot`. These are sectors 69 and 70 when `boot_top`=1, and sectors 0 and 1 when `boot_top`=0.
- R11: With `boot_lock_n`=1, the two outermost boot sectors follow their stored group bits.
- R12: With `temp_unprot`=1 and `accel`=0, `wr_ok` is 1 for every sector not held by R10. When `temp_unprot` returns to 0, the stored protection applies again unchanged.
- R13: With `accel`=1, `wr_ok` is 1 for every address.
- R14: `sector`, `boot_bank`, `group`, `verify_data` and `wr_ok` follow the inputs in the same cycle, with no register on the path.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 21 | Word address |
| boot_top | input | 1 | 1 = boot block at the highest addresses, 0 = at the lowest |
| boot_lock_n | input | 1 | 0 keeps the two outermost boot sectors non-writable |
| accel | input | 1 | High-voltage acceleration mode: every sector writable |
| temp_unprot | input | 1 | Temporary unprotect of all stored groups |
| prot_set | input | 1 | Set the bit of the addressed group |
| unprot_all | input | 1 | Clear all group bits if all are set |
| sector | output | 7 | Sector index 0..70 |
| boot_bank | output | 1 | Address lies in the 4-Mbit boot bank |
| group | output | 5 | Protection group index 0..24 |
| wr_ok | output | 1 | Program or erase at this address is allowed |
| verify_data | output | 16 | Protection-verify word of the addressed group |
| unprot_err | output | 1 | Last unprotect request was refused |

## Verification
The decode outputs, `verify_data` and `wr_ok` are combinational. The bench therefore drives the address and mode inputs just after a falling edge and samples them one time unit later, within the same cycle. Protect and unprotect requests are held for exactly one cycle. They are captured at the next rising edge, so their effect on the bits, `verify_data`, `wr_ok` and `unprot_err` is sampled after the following falling edge, one cycle after the request. All expected sectors, groups and banks come from the bench's own range arithmetic, which differs in form from the mirrored decode in the design.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int ADDR_W     = 21;
    localparam int SA_W       = 9;
    localparam int SMALL_N    = 8;
    localparam int SECT_N     = 71;
    localparam int GRP_N      = 25;
    localparam int BOOT_BANK_N = SMALL_N + 7;
    localparam int SECT_W     = $clog2(SECT_N);
    localparam int GRP_W      = $clog2(GRP_N);
    localparam int SMALL_BASE = SECT_N - SMALL_N;
    localparam int TRIO_GRP   = GRP_N - SMALL_N - 1;
    localparam int VERIFY_W   = 16;

    typedef logic [SECT_W-1:0] sect_t;
    typedef logic [GRP_W-1:0]  grp_t;

    typedef struct packed {
        sect_t sector;
        logic  boot_bank;
        grp_t  group;
        logic  outer;
    } loc_t;

    typedef enum logic [1:0] {
        GATE_STORED = 2'd0,
        GATE_TEMP   = 2'd1,
        GATE_LOCKED = 2'd2,
        GATE_ACCEL  = 2'd3
    } gate_src_t;

    // Group of a sector in the top-boot layout; the bottom-boot layout is its mirror.
    function automatic grp_t grp_of_top(input sect_t s);
        sect_t t;
        t = s - sect_t'(4);
        if (s == sect_t'(0))
            return grp_t'(0);
        else if (s < sect_t'(4))
            return grp_t'(1);
        else if (s < sect_t'(SMALL_BASE - 3))
            return grp_t'(2) + grp_t'(t >> 2);
        else if (s < sect_t'(SMALL_BASE))
            return grp_t'(TRIO_GRP);
        else
            return grp_t'(TRIO_GRP + 1) + grp_t'(s - sect_t'(SMALL_BASE));
    endfunction

endpackage

// File: rtl/bsp_sector_decode.sv
module bsp_sector_decode
    import bsp_pkg::*;
#(
    parameter int ADDR_W = bsp_pkg::ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_top,
    output loc_t              loc
);
    localparam int HI = SA_W - 3;

    logic [SA_W-1:0] field;
    logic [HI-1:0]   big;
    sect_t           sec;
    sect_t           mirror;

    assign field = addr[ADDR_W-1 -: SA_W];
    assign big   = field[SA_W-1:3];

    always_comb begin
        if (boot_top) begin
            if (&big)
                sec = sect_t'(SMALL_BASE) + sect_t'(field[2:0]);
            else
                sec = sect_t'(big);
        end else begin
            if (big == '0)
                sec = sect_t'(field[2:0]);
            else
                sec = sect_t'(big) + sect_t'(SMALL_N - 1);
        end
        mirror = sect_t'(SECT_N - 1) - sec;

        loc.sector = sec;
        if (boot_top) begin
            loc.boot_bank = (sec >= sect_t'(SECT_N - BOOT_BANK_N));
            loc.group     = grp_of_top(sec);
            loc.outer     = (sec >= sect_t'(SECT_N - 2));
        end else begin
            loc.boot_bank = (sec < sect_t'(BOOT_BANK_N));
            loc.group     = grp_t'(GRP_N - 1) - grp_of_top(mirror);
            loc.outer     = (sec < sect_t'(2));
        end
    end
endmodule

// File: rtl/bsp_group_store.sv
module bsp_group_store
    import bsp_pkg::*;
#(
    parameter int N = bsp_pkg::GRP_N
) (
    input  logic         clk,
    input  logic         rst,
    input  grp_t         group,
    input  logic         prot_set,
    input  logic         unprot_all,
    output logic [N-1:0] bits,
    output logic         bit_sel,
    output logic         unprot_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bits       <= '0;
            unprot_err <= 1'b0;
        end else if (unprot_all) begin
            if (&bits) begin
                bits       <= '0;
                unprot_err <= 1'b0;
            end else begin
                unprot_err <= 1'b1;
            end
        end else if (prot_set) begin
            bits[group] <= 1'b1;
        end
    end

    assign bit_sel = bits[group];
endmodule

// File: rtl/bsp_write_gate.sv
module bsp_write_gate
    import bsp_pkg::*;
(
    input  logic      stored,
    input  logic      outer,
    input  logic      accel,
    input  logic      boot_lock_n,
    input  logic      temp_unprot,
    output gate_src_t src,
    output logic      wr_ok
);
    always_comb begin
        if (accel)
            src = GATE_ACCEL;
        else if (outer && !boot_lock_n)
            src = GATE_LOCKED;
        else if (temp_unprot)
            src = GATE_TEMP;
        else
            src = GATE_STORED;

        unique case (src)
            GATE_ACCEL:  wr_ok = 1'b1;
            GATE_LOCKED: wr_ok = 1'b0;
            GATE_TEMP:   wr_ok = 1'b1;
            default:     wr_ok = !stored;
        endcase
    end
endmodule

// File: rtl/bsp_top.sv
module bsp_top
    import bsp_pkg::*;
#(
    parameter int ADDR_W   = bsp_pkg::ADDR_W,
    parameter int VERIFY_W = bsp_pkg::VERIFY_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                boot_top,
    input  logic                boot_lock_n,
    input  logic                accel,
    input  logic                temp_unprot,
    input  logic                prot_set,
    input  logic                unprot_all,
    output logic [SECT_W-1:0]   sector,
    output logic                boot_bank,
    output logic [GRP_W-1:0]    group,
    output logic                wr_ok,
    output logic [VERIFY_W-1:0] verify_data,
    output logic                unprot_err
);
    loc_t             loc;
    logic [GRP_N-1:0] grp_bits;
    logic             bit_sel;
    gate_src_t        src;

    bsp_sector_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr     (addr),
        .boot_top (boot_top),
        .loc      (loc)
    );

    bsp_group_store #(.N(GRP_N)) store_i (
        .clk        (clk),
        .rst        (rst),
        .group      (loc.group),
        .prot_set   (prot_set),
        .unprot_all (unprot_all),
        .bits       (grp_bits),
        .bit_sel    (bit_sel),
        .unprot_err (unprot_err)
    );

    bsp_write_gate gate_i (
        .stored      (bit_sel),
        .outer       (loc.outer),
        .accel       (accel),
        .boot_lock_n (boot_lock_n),
        .temp_unprot (temp_unprot),
        .src         (src),
        .wr_ok       (wr_ok)
    );

    assign sector      = loc.sector;
    assign boot_bank   = loc.boot_bank;
    assign group       = loc.group;
    assign verify_data = {{(VERIFY_W-1){1'b0}}, bit_sel};
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker
    import bsp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             boot_top,
    input logic             boot_lock_n,
    input logic             accel,
    input logic             temp_unprot,
    input logic             prot_set,
    input logic             unprot_all,
    input logic [SECT_W-1:0] sector,
    input logic             boot_bank,
    input logic [GRP_W-1:0] group,
    input logic             wr_ok,
    input logic [15:0]      verify_data,
    input logic             unprot_err,
    input logic [GRP_N-1:0] grp_bits
);
    logic is_outer;
    logic is_small;
    assign is_outer = boot_top ? (sector >= SECT_W'(SECT_N - 2)) : (sector < SECT_W'(2));
    assign is_small = boot_top ? (sector >= SECT_W'(SMALL_BASE)) : (sector < SECT_W'(SMALL_N));

    assert_small_in_bank_R3: assert property (@(posedge clk) disable iff (rst)
        is_small |-> boot_bank);

    assert_group_range_R4: assert property (@(posedge clk) disable iff (rst)
        group < GRP_W'(GRP_N));

    assert_protect_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (prot_set && !unprot_all) |=> grp_bits[$past(group)]);

    assert_unprot_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (unprot_all && (&grp_bits)) |=> (grp_bits == '0 && !unprot_err));

    assert_unprot_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (unprot_all && !(&grp_bits)) |=> (unprot_err && grp_bits == $past(grp_bits)));

    assert_verify_upper_R8: assert property (@(posedge clk) disable iff (rst)
        verify_data[15:1] == '0);

    assert_boot_lock_R10: assert property (@(posedge clk) disable iff (rst)
        (!accel && !boot_lock_n && is_outer) |-> !wr_ok);

    assert_temp_open_R12: assert property (@(posedge clk) disable iff (rst)
        (temp_unprot && boot_lock_n) |-> wr_ok);

    assert_accel_open_R13: assert property (@(posedge clk) disable iff (rst)
        accel |-> wr_ok);
endmodule

bind bsp_top bsp_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .boot_top    (boot_top),
    .boot_lock_n (boot_lock_n),
    .accel       (accel),
    .temp_unprot (temp_unprot),
    .prot_set    (prot_set),
    .unprot_all  (unprot_all),
    .sector      (sector),
    .boot_bank   (boot_bank),
    .group       (group),
    .wr_ok       (wr_ok),
    .verify_data (verify_data),
    .unprot_err  (unprot_err),
    .grp_bits    (grp_bits)
);

// File: tb/bsp_top_tb.sv
module bsp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] addr = '0;
    logic        boot_top = 1'b1;
    logic        boot_lock_n = 1'b1;
    logic        accel = 1'b0;
    logic        temp_unprot = 1'b0;
    logic        prot_set = 1'b0;
    logic        unprot_all = 1'b0;
    logic [6:0]  sector;
    logic        boot_bank;
    logic [4:0]  group;
    logic        wr_ok;
    logic [15:0] verify_data;
    logic        unprot_err;

    int checks = 0;
    int fails  = 0;
    logic exp_bits [25];

    always #5 clk = ~clk;

    bsp_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .boot_top(boot_top),
        .boot_lock_n(boot_lock_n), .accel(accel), .temp_unprot(temp_unprot),
        .prot_set(prot_set), .unprot_all(unprot_all), .sector(sector),
        .boot_bank(boot_bank), .group(group), .wr_ok(wr_ok),
        .verify_data(verify_data), .unprot_err(unprot_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bench reference model, written as plain address ranges.
    function automatic int m_sector(input logic top, input int a);
        if (top) return (a < 'h1F8000) ? (a >> 15) : 63 + ((a - 'h1F8000) >> 12);
        else     return (a < 'h8000) ? (a >> 12) : 7 + (a >> 15);
    endfunction

    function automatic int m_group(input logic top, input int s);
        if (top) begin
            if (s == 0) return 0;
            if (s <= 3) return 1;
            if (s <= 59) return 2 + (s - 4) / 4;
            if (s <= 62) return 16;
            return 17 + s - 63;
        end else begin
            if (s <= 7) return s;
            if (s <= 10) return 8;
            if (s <= 66) return 9 + (s - 11) / 4;
            if (s <= 69) return 23;
            return 24;
        end
    endfunction

    function automatic int m_bank(input logic top, input int s);
        return top ? int'(s >= 56) : int'(s <= 14);
    endfunction

    function automatic int addr_of(input logic top, input int s);
        if (top) return (s < 63) ? (s << 15) : 'h1F8000 + ((s - 63) << 12) + 'h21;
        else     return (s < 8) ? (s << 12) + 'h13 : ((s - 7) << 15) + 'h40;
    endfunction

    task automatic go(input logic top, input int s);
        @(negedge clk);
        boot_top = top;
        addr = 21'(addr_of(top, s));
        #1;
    endtask

    task automatic pulse_protect(input logic top, input int s);
        go(top, s);
        prot_set = 1'b1;
        @(negedge clk);
        prot_set = 1'b0;
        exp_bits[m_group(top, s)] = 1'b1;
        #1;
    endtask

    task automatic pulse_unprot();
        logic all;
        all = 1'b1;
        foreach (exp_bits[i]) all &= exp_bits[i];
        @(negedge clk);
        unprot_all = 1'b1;
        @(negedge clk);
        unprot_all = 1'b0;
        if (all) foreach (exp_bits[i]) exp_bits[i] = 1'b0;
        #1;
        chk("R7", "unprot_err", int'(unprot_err), int'(!all));
    endtask

    task automatic t_reset();
        foreach (exp_bits[i]) exp_bits[i] = 1'b0;
        for (int s = 0; s < 71; s += 10) begin
            go(1'b1, s);
            chk("R5", "verify after reset", int'(verify_data), 0);
            chk("R5", "wr_ok after reset", int'(wr_ok), 1);
        end
        chk("R5", "unprot_err after reset", int'(unprot_err), 0);
    endtask

    task automatic t_decode();
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 512; f++) begin
                int a, s;
                @(negedge clk);
                boot_top = (m == 0);
                a = (f << 12) | 'h3C7;
                addr = 21'(a);
                #1;
                s = m_sector(boot_top, a);
                chk(m == 0 ? "R1" : "R2", "sector", int'(sector), s);
                chk("R3", "boot_bank", int'(boot_bank), m_bank(boot_top, s));
                chk("R4", "group", int'(group), m_group(boot_top, s));
                chk("R14", "verify same cycle", int'(verify_data), 0);
            end
        end
    endtask

    task automatic t_protect_one();
        pulse_protect(1'b1, 30);
        go(1'b1, 30);
        chk("R6", "verify protected group", int'(verify_data), 1);
        chk("R8", "verify word", int'(verify_data), 'h0001);
        chk("R9", "wr_ok protected", int'(wr_ok), 0);
        go(1'b1, 20);
        chk("R6", "neighbour untouched", int'(verify_data), 0);
        chk("R9", "wr_ok unprotected", int'(wr_ok), 1);
        pulse_protect(1'b0, 9);
        go(1'b0, 10);
        chk("R6", "bottom trio group", int'(verify_data), 1);
        go(1'b0, 11);
        chk("R8", "bottom next group", int'(verify_data), 'h0000);
    endtask

    task automatic t_unprot_refused();
        pulse_unprot();
        go(1'b1, 30);
        chk("R7", "bits kept after refusal", int'(verify_data), 1);
        go(1'b1, 40);
        @(negedge clk);
        prot_set = 1'b1;
        unprot_all = 1'b1;
        @(negedge clk);
        prot_set = 1'b0;
        unprot_all = 1'b0;
        #1;
        chk("R7", "protect ignored with unprotect", int'(verify_data), 0);
        chk("R7", "err with same-cycle protect", int'(unprot_err), 1);
        repeat (3) @(negedge clk);
        #1;
        chk("R7", "err held", int'(unprot_err), 1);
    endtask

    task automatic t_unprot_ok();
        for (int s = 0; s < 71; s++) pulse_protect(1'b1, s);
        for (int s = 0; s < 71; s += 7) begin
            go(1'b1, s);
            chk("R6", "all protected", int'(verify_data), 1);
        end
        pulse_unprot();
        for (int s = 0; s < 71; s += 5) begin
            go(1'b0, s);
            chk("R7", "all cleared", int'(verify_data), 0);
        end
    endtask

    task automatic t_temp();
        pulse_protect(1'b1, 30);
        go(1'b1, 30);
        chk("R9", "protected blocks", int'(wr_ok), 0);
        temp_unprot = 1'b1;
        #1;
        chk("R12", "temp opens", int'(wr_ok), 1);
        @(negedge clk);
        temp_unprot = 1'b0;
        #1;
        chk("R12", "stored applies again", int'(wr_ok), 0);
        chk("R12", "bit unchanged", int'(verify_data), 1);
        accel = 1'b1;
        #1;
        chk("R13", "accel opens protected", int'(wr_ok), 1);
        accel = 1'b0;
    endtask

    task automatic t_outer();
        boot_lock_n = 1'b0;
        go(1'b1, 70); chk("R10", "top s70 locked", int'(wr_ok), 0);
        go(1'b1, 69); chk("R10", "top s69 locked", int'(wr_ok), 0);
        go(1'b1, 68); chk("R10", "top s68 free", int'(wr_ok), 1);
        go(1'b1, 70);
        temp_unprot = 1'b1;
        #1;
        chk("R10", "lock beats temp", int'(wr_ok), 0);
        temp_unprot = 1'b0;
        accel = 1'b1;
        #1;
        chk("R13", "accel beats lock", int'(wr_ok), 1);
        accel = 1'b0;
        go(1'b0, 0); chk("R10", "bottom s0 locked", int'(wr_ok), 0);
        go(1'b0, 1); chk("R10", "bottom s1 locked", int'(wr_ok), 0);
        go(1'b0, 2); chk("R10", "bottom s2 free", int'(wr_ok), 1);
        boot_lock_n = 1'b1;
        go(1'b1, 70); chk("R11", "s70 follows clear bit", int'(wr_ok), 1);
        pulse_protect(1'b1, 70);
        go(1'b1, 70); chk("R11", "s70 follows set bit", int'(wr_ok), 0);
        go(1'b1, 69); chk("R11", "s69 own group clear", int'(wr_ok), 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_protect_one();
        t_unprot_refused();
        t_unprot_ok();
        t_temp();
        t_outer();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule